// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. It watches a free-running main counter that lives outside the block. When that counter reaches the channel's comparator, the block raises a fire strobe. The channel has two modes. In one-shot mode it fires once per programmed target. In periodic mode it fires, then moves the comparator forward by a hidden period. The counter is natively full width (64 bits by default). A narrow mode uses only the lower half of that width.

Software programs the channel through a small configuration write and a comparator port that is half the counter width. The comparator is written as a low half and a high half. A self-clearing set-value bit decides whether, in periodic mode, a comparator write changes the comparator itself or only the period. The comparator value can be read back. Interrupt routing, status and the counter itself are outside this block. The block uses only the counter value and a global enable.

Top module: `evtc_channel`

## Requirements
- R1: During and after reset the comparator reads all ones, the hidden period is zero, no expiry is pending and `fire` is low.
- R2: A configuration write stores `cfgData` as follows: bit 0 is the channel enable, bit 1 selects periodic mode, bit 2 selects narrow mode and bit 3 is the set-value bit. A low-half or high-half comparator write loads that half of the comparator when the channel is one-shot or set-value is 1. In periodic mode the same write also loads that half of the period.
- R3: Any comparator write, low or high, clears set-value at the same clock edge. A later periodic write then changes only the period.
- R4: The top bit of every value written into the period is forced to zero. This applies to the full-width top bit, and in narrow mode to bit HALF_W-1.
- R5: A configuration write with the narrow bit set clears the upper half of the comparator and of the period, and also period bit HALF_W-1. In narrow mode, high-half writes are ignored and period additions wrap at HALF_W bits.
- R6: In narrow one-shot mode the channel also fires when the lower half of the counter wraps, meaning it is lower than on the previous cycle. It then still fires at the true comparator match.
- R7: The counter counts as having reached the comparator when (comparator − counter), taken at the width of the mode, is zero or negative. `fire` is a single-cycle pulse that appears in the cycle after the clock edge where an armed, active channel first sees the counter reached. The channel is armed when it is active and either sees the counter not yet reached or receives a comparator write. Firing disarms it.
- R8: In periodic mode with a non-zero period, each cycle in which the counter has reached the comparator adds the period to the comparator. This repeats until the comparator is ahead again. Only the first such cycle fires. A comparator write in the same cycle takes priority over the addition.
- R9: While the channel enable or `globalEn` is low the channel never fires and any pending expiry is dropped. Re-enabling with the counter already past the comparator does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Global timer enable |
| counter | input | CNT_W | Main counter value |
| cfgWr | input | 1 | Configuration write strobe |
| cfgData | input | 4 | Configuration value (enable, periodic, narrow, set-value) |
| cmpWrLo | input | 1 | Write low half of the comparator port |
| cmpWrHi | input | 1 | Write high half of the comparator port |
| wrData | input | CNT_W/2 | Comparator write data |
| fire | output | 1 | Single-cycle expiry strobe |
| cmpValue | output | CNT_W | Current comparator value |

## Verification
The hardest case to reach is periodic catch-up. Here the comparator falls many periods behind the counter, so it must advance over several cycles and fire only once. The stimulus reaches it by writing a small comparator value while the counter sits far ahead, then holding the counter still. The comparator then steps forward one period per cycle, and the bench observes each step on `cmpValue`. The narrow-mode wrap fire is reached in a similar way. The bench drives the counter directly to values just below and just past a half-width boundary, with no need to count through the range.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

  localparam int CFG_EN       = 0;
  localparam int CFG_PERIODIC = 1;
  localparam int CFG_NARROW   = 2;
  localparam int CFG_SETVAL   = 3;
  localparam int CFG_W        = 4;

  typedef struct packed {
    logic loadCmpLo;
    logic loadCmpHi;
    logic loadPerLo;
    logic loadPerHi;
    logic advance;
    logic truncate;
    logic narrow;
  } dpStrobe_t;

endpackage

// File: rtl/evtc_dp.sv
module evtc_dp
  import evtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobes,
  input  logic [CNT_W-1:0]     counter,
  input  logic [CNT_W/2-1:0]   wrData,
  output logic                 reached,
  output logic                 periodZero,
  output logic [CNT_W-1:0]     cmpReg
);

  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  perReg;
  logic [CNT_W-1:0]  diffFull;
  logic [HALF_W-1:0] diffNarrow;
  logic [HALF_W-1:0] sumNarrow;
  logic [HALF_W-1:0] perLoMasked;
  logic [HALF_W-1:0] perHiMasked;

  assign diffFull   = cmpReg - counter;
  assign diffNarrow = cmpReg[HALF_W-1:0] - counter[HALF_W-1:0];
  assign sumNarrow  = cmpReg[HALF_W-1:0] + perReg[HALF_W-1:0];

  always_comb begin
    if (strobes.narrow) begin
      reached    = diffNarrow[HALF_W-1] | (diffNarrow == '0);
      periodZero = (perReg[HALF_W-1:0] == '0);
    end else begin
      reached    = diffFull[CNT_W-1] | (diffFull == '0);
      periodZero = (perReg == '0);
    end
  end

  assign perLoMasked = strobes.narrow ? {1'b0, wrData[HALF_W-2:0]} : wrData;
  assign perHiMasked = {1'b0, wrData[HALF_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg <= '1;
      perReg <= '0;
    end else begin
      if (strobes.advance) begin
        if (strobes.narrow) cmpReg <= {{HALF_W{1'b0}}, sumNarrow};
        else                cmpReg <= cmpReg + perReg;
      end
      if (strobes.loadCmpLo) cmpReg[HALF_W-1:0]     <= wrData;
      if (strobes.loadCmpHi) cmpReg[CNT_W-1:HALF_W] <= wrData;
      if (strobes.loadPerLo) perReg[HALF_W-1:0]     <= perLoMasked;
      if (strobes.loadPerHi) perReg[CNT_W-1:HALF_W] <= perHiMasked;
      if (strobes.truncate) begin
        cmpReg[CNT_W-1:HALF_W] <= '0;
        perReg[CNT_W-1:HALF_W] <= '0;
        perReg[HALF_W-1]       <= 1'b0;
      end
    end
  end

  // R5
  narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.narrow |-> (cmpReg[CNT_W-1:HALF_W] == '0) && (perReg[CNT_W-1:HALF_W] == '0));

  // R4
  period_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !perReg[CNT_W-1] && (!strobes.narrow || !perReg[HALF_W-1]));

  // R2
  load_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCmpLo |=> cmpReg[HALF_W-1:0] == $past(wrData));

endmodule

// File: rtl/evtc_ctrl.sv
module evtc_ctrl
  import evtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [CNT_W-1:0]   counter,
  input  logic               cfgWr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               cmpWrLo,
  input  logic               cmpWrHi,
  input  logic               reached,
  input  logic               periodZero,
  output dpStrobe_t          strobes,
  output logic               fire
);

  localparam int HALF_W = CNT_W / 2;

  logic chanEnQ, periodicQ, narrowQ, setValQ;
  logic armedQ, prevActiveQ;
  logic [HALF_W-1:0] prevLoQ;
  logic active, cmpWrAny, loadCmp, matchFire, wrapFire;

  assign active    = chanEnQ & globalEn;
  assign cmpWrAny  = cmpWrLo | cmpWrHi;
  assign loadCmp   = !periodicQ | setValQ;
  assign matchFire = active & armedQ & reached;
  assign wrapFire  = active & prevActiveQ & narrowQ & !periodicQ &
                     (counter[HALF_W-1:0] < prevLoQ);

  always_comb begin
    strobes.loadCmpLo = cmpWrLo & loadCmp;
    strobes.loadCmpHi = cmpWrHi & loadCmp & !narrowQ;
    strobes.loadPerLo = cmpWrLo & periodicQ;
    strobes.loadPerHi = cmpWrHi & periodicQ & !narrowQ;
    strobes.advance   = active & reached & periodicQ & !periodZero & !cmpWrAny;
    strobes.truncate  = cfgWr & cfgData[CFG_NARROW];
    strobes.narrow    = narrowQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnQ     <= 1'b0;
      periodicQ   <= 1'b0;
      narrowQ     <= 1'b0;
      setValQ     <= 1'b0;
      armedQ      <= 1'b0;
      prevActiveQ <= 1'b0;
      prevLoQ     <= '0;
      fire        <= 1'b0;
    end else begin
      if (cfgWr) begin
        chanEnQ   <= cfgData[CFG_EN];
        periodicQ <= cfgData[CFG_PERIODIC];
        narrowQ   <= cfgData[CFG_NARROW];
      end
      if (cmpWrAny)   setValQ <= 1'b0;
      else if (cfgWr) setValQ <= cfgData[CFG_SETVAL];

      if (!active)        armedQ <= 1'b0;
      else if (cmpWrAny)  armedQ <= 1'b1;
      else if (matchFire) armedQ <= 1'b0;
      else if (!reached)  armedQ <= 1'b1;

      prevActiveQ <= active;
      prevLoQ     <= counter[HALF_W-1:0];
      fire        <= matchFire | wrapFire;
    end
  end

  // R9
  inactive_no_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !fire);

  // R3
  setval_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrAny |=> !setValQ);

  // R6
  wrap_only_oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !$past(armedQ)) |-> $past(narrowQ && !periodicQ));

endmodule

// File: rtl/evtc_channel.sv
module evtc_channel
  import evtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [CNT_W-1:0]   counter,
  input  logic               cfgWr,
  input  logic [3:0]         cfgData,
  input  logic               cmpWrLo,
  input  logic               cmpWrHi,
  input  logic [CNT_W/2-1:0] wrData,
  output logic               fire,
  output logic [CNT_W-1:0]   cmpValue
);

  dpStrobe_t strobes;
  logic      reached;
  logic      periodZero;

  evtc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .counter(counter),
    .cfgWr(cfgWr), .cfgData(cfgData), .cmpWrLo(cmpWrLo), .cmpWrHi(cmpWrHi),
    .reached(reached), .periodZero(periodZero), .strobes(strobes), .fire(fire)
  );

  evtc_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .counter(counter),
    .wrData(wrData), .reached(reached), .periodZero(periodZero), .cmpReg(cmpValue)
  );

endmodule

// File: tb/evtc_channel_tb_top.sv
module evtc_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b1;
  logic [63:0] counter = '0;
  logic        cfgWr = 1'b0;
  logic [3:0]  cfgData = '0;
  logic        cmpWrLo = 1'b0;
  logic        cmpWrHi = 1'b0;
  logic [31:0] wrData = '0;
  logic        fire;
  logic [63:0] cmpValue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evtc_channel dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .counter(counter),
    .cfgWr(cfgWr), .cfgData(cfgData), .cmpWrLo(cmpWrLo), .cmpWrHi(cmpWrHi),
    .wrData(wrData), .fire(fire), .cmpValue(cmpValue)
  );

  typedef struct packed {
    logic [63:0] cnt;
    logic        expFire;
    logic [63:0] expCmp;
  } vec_t;

  // periodic full-width, comparator 10, period 10
  localparam vec_t VECS [8] = '{
    '{64'd5,  1'b0, 64'd10},
    '{64'd9,  1'b0, 64'd10},
    '{64'd10, 1'b1, 64'd20},
    '{64'd11, 1'b0, 64'd20},
    '{64'd20, 1'b1, 64'd30},
    '{64'd25, 1'b0, 64'd30},
    '{64'd30, 1'b1, 64'd40},
    '{64'd31, 1'b0, 64'd40}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [3:0] cd, input logic lo, input logic hi,
                       input logic [31:0] d, input logic [63:0] cnt, input logic ge);
    @(negedge clk);
    cfgWr = c; cfgData = cd; cmpWrLo = lo; cmpWrHi = hi; wrData = d;
    counter = cnt; globalEn = ge;
    @(posedge clk);
    #1;
    cfgWr = 1'b0; cmpWrLo = 1'b0; cmpWrHi = 1'b0;
  endtask

  task automatic step(input logic [63:0] cnt);
    drive(1'b0, 4'h0, 1'b0, 1'b0, 32'h0, cnt, 1'b1);
  endtask

  task automatic cfg(input logic [3:0] cd, input logic [63:0] cnt);
    drive(1'b1, cd, 1'b0, 1'b0, 32'h0, cnt, 1'b1);
  endtask

  task automatic wrLo(input logic [31:0] d, input logic [63:0] cnt);
    drive(1'b0, 4'h0, 1'b1, 1'b0, d, cnt, 1'b1);
  endtask

  task automatic wrHi(input logic [31:0] d, input logic [63:0] cnt);
    drive(1'b0, 4'h0, 1'b0, 1'b1, d, cnt, 1'b1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "fire in reset", {63'd0, fire}, 64'd0);
    chk("R1", "cmp in reset", cmpValue, '1);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "cmp after reset", cmpValue, '1);

    // R2 setup: periodic + set-value, high half then low half
    cfg(4'hA, 64'd0);
    wrHi(32'h0, 64'd0);
    chk("R2", "cmp high loaded with set-value", cmpValue, 64'h0000_0000_FFFF_FFFF);
    cfg(4'hA, 64'd0);
    wrLo(32'd10, 64'd0);
    chk("R2", "cmp low loaded with set-value", cmpValue, 64'd10);
    cfg(4'h3, 64'd0);

    // R7 R8 periodic vector walk
    for (int i = 0; i < 8; i++) begin
      step(VECS[i].cnt);
      chk("R7", $sformatf("fire vec %0d", i), {63'd0, fire}, {63'd0, VECS[i].expFire});
      chk("R8", $sformatf("cmp vec %0d", i), cmpValue, VECS[i].expCmp);
    end

    // R8 catch-up: comparator far behind the counter
    cfg(4'hB, 64'd31);
    wrLo(32'd5, 64'd35);
    chk("R2", "periodic set-value load", cmpValue, 64'd5);
    step(64'd60);
    chk("R8", "first catch-up fire", {63'd0, fire}, 64'd1);
    chk("R8", "cmp after first add", cmpValue, 64'd10);
    for (int k = 0; k < 11; k++) begin
      step(64'd60);
      chk("R8", $sformatf("no fire during catch-up %0d", k), {63'd0, fire}, 64'd0);
      chk("R8", $sformatf("catch-up cmp %0d", k), cmpValue, 64'd15 + 64'(5 * k));
    end
    step(64'd62);
    chk("R8", "idle ahead", {63'd0, fire}, 64'd0);
    step(64'd65);
    chk("R8", "fire after catch-up", {63'd0, fire}, 64'd1);
    chk("R8", "cmp after catch-up fire", cmpValue, 64'd70);

    // R3 set-value cleared: periodic write changes only the period
    wrLo(32'd100, 64'd66);
    chk("R3", "cmp kept after set-value cleared", cmpValue, 64'd70);
    step(64'd70);
    chk("R3", "fire at kept cmp", {63'd0, fire}, 64'd1);
    chk("R2", "new period applied", cmpValue, 64'd170);

    // R5 truncation in narrow mode
    cfg(4'h0, 64'd0);
    wrHi(32'h1234_5678, 64'd0);
    chk("R2", "one-shot high write", cmpValue, 64'h1234_5678_0000_00AA);
    cfg(4'h4, 64'd0);
    chk("R5", "narrow truncates cmp", cmpValue, 64'h0000_0000_0000_00AA);
    wrHi(32'hDEAD_BEEF, 64'd0);
    chk("R5", "narrow ignores high write", cmpValue, 64'h0000_0000_0000_00AA);

    // R4 period top bit cleared, narrow periodic wrap of addition
    cfg(4'hE, 64'd0);
    wrLo(32'hFFFF_FFF0, 64'd0);
    cfg(4'h7, 64'h0000_0000_FFFF_FFE0);
    step(64'h0000_0000_FFFF_FFE0);
    chk("R7", "narrow not reached", {63'd0, fire}, 64'd0);
    step(64'h0000_0000_FFFF_FFF0);
    chk("R7", "narrow match fire", {63'd0, fire}, 64'd1);
    chk("R4", "period msb clamp", cmpValue, 64'h0000_0000_7FFF_FFE0);

    // R6 narrow one-shot wrap fire
    cfg(4'h4, 64'd0);
    wrLo(32'h10, 64'd0);
    cfg(4'h5, 64'h1_FFFF_FFF0);
    step(64'h1_FFFF_FFFF);
    chk("R6", "no fire before wrap", {63'd0, fire}, 64'd0);
    step(64'h2_0000_0000);
    chk("R6", "wrap fire", {63'd0, fire}, 64'd1);
    step(64'h2_0000_0005);
    chk("R6", "quiet after wrap", {63'd0, fire}, 64'd0);
    step(64'h2_0000_0010);
    chk("R6", "match fire after wrap", {63'd0, fire}, 64'd1);
    step(64'h2_0000_0011);
    chk("R6", "one-shot single match", {63'd0, fire}, 64'd0);
    chk("R6", "one-shot cmp unchanged", cmpValue, 64'h10);

    // R9 channel disable cancels pending expiry
    cfg(4'h1, 64'h50);
    wrLo(32'h100, 64'h50);
    cfg(4'h0, 64'h60);
    step(64'h70);
    cfg(4'h1, 64'h80);
    step(64'h100);
    chk("R9", "no fire after channel re-enable", {63'd0, fire}, 64'd0);
    step(64'h101);
    chk("R9", "still quiet", {63'd0, fire}, 64'd0);

    // R9 global enable
    wrLo(32'h200, 64'h150);
    drive(1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 64'h200, 1'b0);
    chk("R9", "no fire with global off", {63'd0, fire}, 64'd0);
    step(64'h200);
    chk("R9", "pending dropped by global off", {63'd0, fire}, 64'd0);
    step(64'h1FF);
    step(64'h200);
    chk("R7", "re-armed fire", {63'd0, fire}, 64'd1);
    step(64'h201);
    chk("R7", "single-cycle pulse", {63'd0, fire}, 64'd0);

    summary();
  end

endmodule